// File: doc/BRIEF.md
# Serial Link Error Monitor

The block watches a receiver's stream of decoded link words. It decides whether the receiver may keep passing received data downstream. Each word arrives with a valid strobe and two flags. One flag marks an 8b10b code violation. The other marks any other link error. When accumulation is enabled, the monitor counts flagged words in two counters at once:

- A current-run counter, which runs from the last clear.
- A window counter, which covers a fixed number of valid words. At the end of each window, its total is captured into a previous-window register.

Every cycle, the current-run count is compared with a programmable 16-bit threshold. If the count rises above the threshold, the monitor leaves its normal state. Leaving normal state drops the forwarding enable and the lock contribution. An override bit can keep the monitor in normal state regardless of the count.

A small write-only register port sets up the block:

- Address 0 is a control byte.
- Address 1 holds the low byte of the threshold.
- Address 2 holds the high byte of the threshold.

One output reports either the run count or the last window count, chosen by a select bit.

Top module: `link_err_mon`

## Requirements
- R1: The threshold is 16 bits, written as its low byte at address 1 and its high byte at address 2, and resets to 0x0010.
- R2: While control bit 0 (accumulate) is 0, no error changes either count.
- R3: While control bit 1 (mask) is 1, a code violation is neither counted nor able to lower `lock_ok`. While the mask is 0, a code violation on a valid word is counted and lowers `lock_ok` in the following cycle.
- R4: Writing 1 to control bit 2 (clear) zeroes the run, window and previous-window counts and the window position one cycle after the write. The bit needs no write to return to 0.
- R5: Control bit 3 (select) picks what `cnt_out` shows. A value of 0 shows the run count and a value of 1 shows the last completed window count.
- R6: When the run count is strictly greater than the threshold and the override is 0, `fwd_en` drops on the next clock edge.
- R7: While control bit 4 (override) is 1, the block stays in normal state at any count.
- R8: Once out of normal state, the block stays out, with all counts frozen, until a clear or reset returns it to normal with counts at zero.
- R9: Counts saturate at 0xFFFF.
- R10: After every WIN_LEN valid words counted in normal state, the errors seen in them are captured as the previous-window count, and the window count restarts.
- R11: After reset, all control bits are 0, all counts are 0, and `fwd_en` and `lock_ok` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | A decoded word is present this cycle |
| code_err | input | 1 | The word has an 8b10b code violation |
| link_err | input | 1 | The word has some other link error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 threshold low, 2 threshold high) |
| reg_wdata | input | 8 | Register write data |
| cnt_out | output | 16 | Selected error count |
| fwd_en | output | 1 | Received data may be forwarded (normal state) |
| lock_ok | output | 1 | Contribution to the receiver lock status |

## Verification
The threshold decision is driven in several ways:

- Bursts that stop exactly at the reset threshold and at a threshold programmed through both bytes, then one error more. This separates strict greater-than from greater-or-equal and shows that the high byte is used.
- The same burst under the override, and then with the override released. This separates blocking the exit from ignoring the count.
- Code violations alone, with the mask set and with it clear. This shows whether counting and the lock output follow the mask.

A full window with a known error count, followed by a partial window, shows that the previous-window register changes only at a window boundary. A long run of errors shows saturation rather than wrap.

// File: rtl/link_err_mon.sv
module link_err_mon #(
  parameter int          WIN_LEN = 64,
  parameter logic [15:0] THR_RST = 16'h0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_vld,
  input  logic        code_err,
  input  logic        link_err,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [15:0] cnt_out,
  output logic        fwd_en,
  output logic        lock_ok
);
  localparam int          PW   = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [15:0] CMAX = 16'hFFFF;

  logic          acc, mask, sel, hold, clr_q, halted, code_hit;
  logic [15:0]   thr, run_cnt, win_cnt, prev_cnt;
  logic [PW-1:0] pos;

  wire        err     = word_vld & ((code_err & ~mask) | link_err);
  wire        inc     = acc & err & ~halted;
  wire        win_end = word_vld && (pos == PW'(WIN_LEN - 1));
  wire [15:0] win_nxt = (inc && win_cnt != CMAX) ? win_cnt + 16'd1 : win_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {acc, mask, sel, hold, clr_q, halted, code_hit} <= '0;
      thr      <= THR_RST;
      run_cnt  <= '0;
      win_cnt  <= '0;
      prev_cnt <= '0;
      pos      <= '0;
    end else begin
      clr_q    <= reg_wr && reg_addr == 2'd0 && reg_wdata[2];
      code_hit <= word_vld & code_err & ~mask;
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    {hold, sel, mask, acc} <= {reg_wdata[4:3], reg_wdata[1:0]};
          2'd1:    thr[7:0]  <= reg_wdata;
          2'd2:    thr[15:8] <= reg_wdata;
          default: ;
        endcase
      end
      if (clr_q) begin
        halted   <= 1'b0;
        run_cnt  <= '0;
        win_cnt  <= '0;
        prev_cnt <= '0;
        pos      <= '0;
      end else if (!halted) begin
        if (run_cnt > thr && !hold) halted <= 1'b1;
        if (inc && run_cnt != CMAX) run_cnt <= run_cnt + 16'd1;
        if (win_end) begin
          prev_cnt <= win_nxt;
          win_cnt  <= '0;
          pos      <= '0;
        end else if (word_vld) begin
          win_cnt <= win_nxt;
          pos     <= pos + PW'(1);
        end
      end
    end
  end

  assign cnt_out = sel ? prev_cnt : run_cnt;
  assign fwd_en  = ~halted;
  assign lock_ok = ~halted & ~code_hit;
endmodule

// File: rtl/link_err_mon_chk.sv
module link_err_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_q,
  input logic        acc,
  input logic        hold,
  input logic        fwd_en,
  input logic [15:0] thr,
  input logic [15:0] run_cnt,
  input logic [15:0] prev_cnt
);
  AST_NO_ACC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (!acc && !clr_q) |=> $stable(run_cnt)); // R2
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) clr_q |=> (run_cnt == 16'd0 && prev_cnt == 16'd0)); // R4
  AST_TRIP_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (fwd_en && !hold && !clr_q && run_cnt > thr) |=> !fwd_en); // R6
  AST_OVERRIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (hold && fwd_en) |=> fwd_en); // R7
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (!fwd_en && !clr_q) |=> !fwd_en); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!fwd_en && !clr_q) |=> $stable(run_cnt)); // R8
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (run_cnt == 16'hFFFF && !clr_q) |=> run_cnt == 16'hFFFF); // R9
endmodule

bind link_err_mon link_err_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_q(clr_q), .acc(acc), .hold(hold),
  .fwd_en(fwd_en), .thr(thr), .run_cnt(run_cnt), .prev_cnt(prev_cnt)
);

// File: tb/sim_link_err_mon.sv
module sim_link_err_mon;
  localparam int WIN = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_vld = 1'b0, code_err = 1'b0, link_err = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [15:0] cnt_out;
  logic fwd_en, lock_ok;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  link_err_mon #(.WIN_LEN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .code_err(code_err),
    .link_err(link_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt_out(cnt_out), .fwd_en(fwd_en), .lock_ok(lock_ok)
  );

  always #4 clk = ~clk;

  // behavioural reference
  bit m_acc, m_mask, m_sel, m_hold, m_clr, m_halt, m_chit;
  int m_thr, m_run, m_win, m_prev, m_pos;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_acc, m_mask, m_sel, m_hold, m_clr, m_halt, m_chit} = '0;
      m_thr = 16; m_run = 0; m_win = 0; m_prev = 0; m_pos = 0;
    end else begin
      bit e, c, nclr;
      e = word_vld && ((code_err && !m_mask) || link_err);
      c = m_acc && e && !m_halt;
      nclr = reg_wr && reg_addr == 0 && reg_wdata[2];
      if (m_clr) begin
        m_halt = 0; m_run = 0; m_win = 0; m_prev = 0; m_pos = 0;
      end else if (!m_halt) begin
        if (m_run > m_thr && !m_hold) m_halt = 1;
        if (c) m_run = (m_run < 65535) ? m_run + 1 : 65535;
        if (word_vld) begin
          int w;
          w = c ? ((m_win < 65535) ? m_win + 1 : 65535) : m_win;
          m_pos++;
          if (m_pos == WIN) begin m_prev = w; m_win = 0; m_pos = 0; end
          else m_win = w;
        end
      end
      m_chit = word_vld && code_err && !m_mask;
      m_clr = nclr;
      if (reg_wr) begin
        if (reg_addr == 0) begin
          m_acc = reg_wdata[0]; m_mask = reg_wdata[1];
          m_sel = reg_wdata[3]; m_hold = reg_wdata[4];
        end else if (reg_addr == 1) m_thr = (m_thr & 'hFF00) | reg_wdata;
        else if (reg_addr == 2) m_thr = (m_thr & 'h00FF) | (int'(reg_wdata) << 8);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 cnt_out vs model", int'(cnt_out), m_sel ? m_prev : m_run);
    chk("R6 fwd_en vs model", int'(fwd_en), int'(!m_halt));
    chk("R3 lock_ok vs model", int'(lock_ok), int'(!m_halt && !m_chit));
  end

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic word(input bit ce, input bit le);
    word_vld = 1'b1; code_err = ce; link_err = le;
    @(negedge clk);
    word_vld = 1'b0; code_err = 1'b0; link_err = 1'b0;
  endtask

  task automatic errs(input int n);
    for (int i = 0; i < n; i++) word(1'b0, 1'b1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R11 reset cnt", int'(cnt_out), 0);
    chk("R11 reset fwd_en", int'(fwd_en), 1);
    chk("R11 reset lock_ok", int'(lock_ok), 1);

    errs(5);
    chk("R2 no accumulate", int'(cnt_out), 0);

    wr(0, 8'h01);
    errs(16);
    chk("R5 run count", int'(cnt_out), 16);
    idle(1);
    chk("R1 reset threshold not exceeded", int'(fwd_en), 1);
    errs(1);
    idle(1);
    chk("R6 trip above threshold", int'(fwd_en), 0);
    errs(3);
    chk("R8 frozen count", int'(cnt_out), 17);
    chk("R8 stays halted", int'(fwd_en), 0);
    wr(0, 8'h05);
    idle(1);
    chk("R4 clear zeroes", int'(cnt_out), 0);
    chk("R8 clear restores", int'(fwd_en), 1);

    wr(0, 8'h03);
    word(1'b1, 1'b0);
    chk("R3 masked lock", int'(lock_ok), 1);
    chk("R3 masked count", int'(cnt_out), 0);
    wr(0, 8'h01);
    word(1'b1, 1'b0);
    chk("R3 unmasked lock", int'(lock_ok), 0);
    chk("R3 unmasked count", int'(cnt_out), 1);
    idle(1);
    chk("R3 lock recovers", int'(lock_ok), 1);

    wr(1, 8'h00); wr(2, 8'h01); wr(0, 8'h05);
    idle(1);
    errs(256);
    idle(1);
    chk("R1 high byte threshold held", int'(fwd_en), 1);
    errs(1);
    idle(1);
    chk("R1 high byte threshold tripped", int'(fwd_en), 0);

    wr(1, 8'h03); wr(2, 8'h00); wr(0, 8'h15);
    idle(1);
    errs(10);
    idle(1);
    chk("R7 override keeps normal", int'(fwd_en), 1);
    chk("R7 counting continues", int'(cnt_out), 10);
    wr(0, 8'h01);
    idle(1);
    chk("R6 exit after override off", int'(fwd_en), 0);

    wr(1, 8'h00); wr(2, 8'hFF); wr(0, 8'h0D);
    idle(1);
    errs(5);
    for (int i = 0; i < WIN - 5; i++) word(1'b0, 1'b0);
    chk("R10 window capture", int'(cnt_out), 5);
    errs(3);
    chk("R10 partial window ignored", int'(cnt_out), 5);
    wr(0, 8'h01);
    chk("R5 select run", int'(cnt_out), 8);

    wr(0, 8'h15);
    idle(1);
    errs(65540);
    chk("R9 saturation", int'(cnt_out), 16'hFFFF);

    idle(2);
    finish_run();
  end
endmodule